// File: doc/BRIEF.md
# Quad DAC Parallel Register Interface

This block is the digital front end of a four-channel digital-to-analogue converter. A host drives an 8-bit parallel bus with an active-low select, an active-low write strobe, a two-bit channel address and a byte-select line. Each channel holds a 10-bit code, so the host writes a channel's input register one byte at a time. The low byte carries code bits 7:0. The high byte carries code bits 9:8.

Every channel keeps two registers: an input register that the bus writes, and a converter register whose value the block presents at its outputs. An active-low load input copies all four input registers into their converter registers in the same clock cycle, so all outputs move together. An active-low asynchronous clear zeroes both register ranks at once. A power-down input is turned into one flag per channel, and a gain select is passed through; neither of them changes any stored code. A synchronous active-high reset stands in for power-on initialisation.

Bus signals are registered in the system clock domain. A write commits on the rising edge of the write strobe, and the data, address and byte-select used are the values sampled in the last clock cycle while the strobe was still low.

Top module: `quad_dac_regif`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four output codes, every `pd_flag` bit and `gain_out` are zero. A reset during operation returns the outputs to zero.
- R2: A rising edge of `wr_n` stores data only if `cs_n` was low in the cycle before that edge. A strobe with `cs_n` high changes no register, so a later load shows the old codes.
- R3: `addr` selects the channel, with `addr[1]` as MSB. Value 0 selects channel 0, whose code is `dac_val[9:0]`; channel k sits at `dac_val[10k+9:10k]`.
- R4: With `byte_hi`=1 a write stores `data[1:0]` into code bits 9:8 and ignores `data[7:2]`. With `byte_hi`=0 it stores `data[7:0]` into bits 7:0. The other byte of the channel is unchanged.
- R5: While `ldac_n` stays high, bus writes update only the input registers; `dac_val` does not change.
- R6: A single cycle of `ldac_n` low copies all four input registers into the output registers on the same clock edge. The outputs change in the second cycle after `ldac_n` is sampled low.
- R7: If `ldac_n` is held low, a write reaches `dac_val` on the same clock edge that it reaches the input register.
- R8: `clr_n` low zeroes all input and output registers at once, without waiting for a clock edge, and keeps them at zero while it stays low.
- R9: A clear takes priority over writes and loads. A write whose strobe edge falls while `clr_n` is low is lost, even with `ldac_n` low.
- R10: One cycle after `pd_n` is sampled, every bit of `pd_flag` equals the inverse of `pd_n`. Power-down leaves every stored code unchanged.
- R11: `gain_out` equals `gain_sel` delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on initialisation) |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; a write commits on its rising edge |
| addr | input | 2 | Channel select, bit 1 is the MSB |
| byte_hi | input | 1 | 1 = high byte (code bits 9:8), 0 = low byte (bits 7:0) |
| data | input | 8 | Parallel data bus, bit 7 is the MSB |
| ldac_n | input | 1 | Active-low load of all output registers |
| clr_n | input | 1 | Asynchronous active-low clear of both register ranks |
| pd_n | input | 1 | Active-low power-down request |
| gain_sel | input | 1 | Output range select, passed through |
| dac_val | output | 40 | Four 10-bit output codes, channel 0 in the low bits |
| pd_flag | output | 4 | Per-channel power-down flag |
| gain_out | output | 1 | Registered gain select |

## Verification
A table of byte writes walks all four addresses with both byte selects. Each write is checked twice: once before a load, to show the output holds, and once after a load, to show the code arrived. The data values put ones in bits 7:2 of high-byte writes, so an ignored field that leaked into the code would show. Values in the two bytes differ, so a write to the wrong byte or the wrong channel would show. Directed sequences follow. One writes all four channels and then loads once, which separates a load that updates all channels together from one that updates channels one by one. Others cover a strobe with select high, a load held low during a write, a clear in the middle of a cycle, a clear racing a write while load is low, power-down with codes present, and a reset during operation.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    localparam int QD_CH   = 4;
    localparam int QD_WORD = 10;
    localparam int QD_BUS  = 8;
    localparam int QD_AW   = $clog2(QD_CH);
    localparam int QD_HI   = QD_WORD - QD_BUS;
    localparam int QD_FLAT = QD_CH * QD_WORD;

    typedef logic [QD_WORD-1:0] code_t;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              ldac_n;
        logic [QD_AW-1:0]  addr;
        logic              hi;
        logic [QD_BUS-1:0] data;
    } bus_sample_t;

    typedef struct packed {
        logic              valid;
        logic [QD_AW-1:0]  chan;
        logic              hi;
        logic [QD_BUS-1:0] data;
    } wr_cmd_t;

    localparam bus_sample_t BUS_IDLE = '{
        cs_n:   1'b1,
        wr_n:   1'b1,
        ldac_n: 1'b1,
        addr:   '0,
        hi:     1'b0,
        data:   '0
    };

    function automatic code_t qd_merge(input code_t old, input logic hi,
                                       input logic [QD_BUS-1:0] d);
        code_t r;
        if (hi) begin
            r = {d[QD_HI-1:0], old[QD_BUS-1:0]};
        end else begin
            r = {old[QD_WORD-1:QD_BUS], d};
        end
        return r;
    endfunction

endpackage

// File: rtl/qdac_bus_capture.sv
module qdac_bus_capture
    import quad_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ldac_n,
    input  logic [QD_AW-1:0]  addr,
    input  logic              hi,
    input  logic [QD_BUS-1:0] data,
    output wr_cmd_t           cmd,
    output logic              load
);

    bus_sample_t cur_q;
    bus_sample_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= BUS_IDLE;
            prev_q <= BUS_IDLE;
        end else begin
            cur_q.cs_n   <= cs_n;
            cur_q.wr_n   <= wr_n;
            cur_q.ldac_n <= ldac_n;
            cur_q.addr   <= addr;
            cur_q.hi     <= hi;
            cur_q.data   <= data;
            prev_q       <= cur_q;
        end
    end

    // Strobe rising: high now, low one sample earlier with select active.
    always_comb begin
        cmd.valid = cur_q.wr_n & ~prev_q.wr_n & ~prev_q.cs_n;
        cmd.chan  = prev_q.addr;
        cmd.hi    = prev_q.hi;
        cmd.data  = prev_q.data;
        load      = ~cur_q.ldac_n;
    end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
    import quad_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              wr_en,
    input  logic              hi,
    input  logic [QD_BUS-1:0] data,
    input  logic              load,
    output code_t             dac_code
);

    code_t in_q;
    code_t in_d;
    code_t out_q;
    code_t out_d;

    always_comb begin
        in_d  = wr_en ? qd_merge(in_q, hi, data) : in_q;
        out_d = load ? in_d : out_q;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            in_q  <= in_d;
            out_q <= out_d;
        end
    end

    assign dac_code = out_q;

endmodule

// File: rtl/qdac_status.sv
module qdac_status
    import quad_dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n,
    input  logic             gain_sel,
    output logic [QD_CH-1:0] pd_flag,
    output logic             gain_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_flag  <= '0;
            gain_out <= 1'b0;
        end else begin
            pd_flag  <= {QD_CH{~pd_n}};
            gain_out <= gain_sel;
        end
    end

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
    import quad_dac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic [QD_AW-1:0]   addr,
    input  logic               byte_hi,
    input  logic [QD_BUS-1:0]  data,
    input  logic               ldac_n,
    input  logic               clr_n,
    input  logic               pd_n,
    input  logic               gain_sel,
    output logic [QD_FLAT-1:0] dac_val,
    output logic [QD_CH-1:0]   pd_flag,
    output logic               gain_out
);

    wr_cmd_t cmd;
    logic    load;

    qdac_bus_capture cap_i (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .ldac_n (ldac_n),
        .addr   (addr),
        .hi     (byte_hi),
        .data   (data),
        .cmd    (cmd),
        .load   (load)
    );

    for (genvar g = 0; g < QD_CH; g++) begin : g_chan
        logic  sel;
        code_t code;

        assign sel = cmd.valid && (cmd.chan == QD_AW'(g));

        qdac_chan chan_i (
            .clk      (clk),
            .rst      (rst),
            .clr_n    (clr_n),
            .wr_en    (sel),
            .hi       (cmd.hi),
            .data     (cmd.data),
            .load     (load),
            .dac_code (code)
        );

        assign dac_val[g*QD_WORD +: QD_WORD] = code;
    end

    qdac_status stat_i (
        .clk      (clk),
        .rst      (rst),
        .pd_n     (pd_n),
        .gain_sel (gain_sel),
        .pd_flag  (pd_flag),
        .gain_out (gain_out)
    );

endmodule

// File: rtl/qdac_regif_chk.sv
module qdac_regif_chk
    import quad_dac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ldac_n,
    input logic               clr_n,
    input logic               pd_n,
    input logic               gain_sel,
    input logic [QD_FLAT-1:0] dac_val,
    input logic [QD_CH-1:0]   pd_flag,
    input logic               gain_out
);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_val == '0));

    assert_hold_no_load_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        ($past(ldac_n, 2) && $past(clr_n) && !$past(rst) && !$past(rst, 2))
        |-> $stable(dac_val));

    assert_pd_follow_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pd_flag == {QD_CH{~$past(pd_n)}}));

    assert_gain_follow_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gain_out == $past(gain_sel)));

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (dac_val == '0 && pd_flag == '0 && !gain_out));

endmodule

bind quad_dac_regif qdac_regif_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ldac_n   (ldac_n),
    .clr_n    (clr_n),
    .pd_n     (pd_n),
    .gain_sel (gain_sel),
    .dac_val  (dac_val),
    .pd_flag  (pd_flag),
    .gain_out (gain_out)
);

// File: tb/quad_dac_regif_tb_top.sv
`timescale 1ns/1ps
module quad_dac_regif_tb_top;
    import quad_dac_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cs_n = 1'b1;
    logic               wr_n = 1'b1;
    logic [1:0]         addr = '0;
    logic               byte_hi = 1'b0;
    logic [7:0]         data = '0;
    logic               ldac_n = 1'b1;
    logic               clr_n = 1'b1;
    logic               pd_n = 1'b1;
    logic               gain_sel = 1'b0;
    logic [QD_FLAT-1:0] dac_val;
    logic [QD_CH-1:0]   pd_flag;
    logic               gain_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [9:0] mdl_in  [4];
    logic [9:0] mdl_out [4];

    always #2 clk = ~clk;

    quad_dac_regif dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .byte_hi(byte_hi), .data(data), .ldac_n(ldac_n), .clr_n(clr_n),
        .pd_n(pd_n), .gain_sel(gain_sel), .dac_val(dac_val),
        .pd_flag(pd_flag), .gain_out(gain_out)
    );

    // Stimulus table: {addr[1:0], byte_hi, data[7:0], expected channel code[9:0]}
    localparam logic [20:0] VEC [10] = '{
        {2'd0, 1'b0, 8'h5A, 10'h05A},
        {2'd0, 1'b1, 8'hFF, 10'h35A},
        {2'd1, 1'b1, 8'h02, 10'h200},
        {2'd1, 1'b0, 8'hC3, 10'h2C3},
        {2'd2, 1'b0, 8'h01, 10'h001},
        {2'd3, 1'b1, 8'hFD, 10'h100},
        {2'd3, 1'b0, 8'hFF, 10'h1FF},
        {2'd2, 1'b1, 8'h03, 10'h301},
        {2'd0, 1'b0, 8'h00, 10'h300},
        {2'd1, 1'b1, 8'h00, 10'h0C3}
    };

    function automatic logic [QD_FLAT-1:0] pack_out();
        logic [QD_FLAT-1:0] r;
        for (int i = 0; i < 4; i++) r[i*10 +: 10] = mdl_out[i];
        return r;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] a, input logic hi, input logic [7:0] d);
        if (hi) mdl_in[a] = {d[1:0], mdl_in[a][7:0]};
        else    mdl_in[a] = {mdl_in[a][9:8], d};
    endtask

    task automatic model_load();
        for (int i = 0; i < 4; i++) mdl_out[i] = mdl_in[i];
    endtask

    task automatic bus_write(input logic [1:0] a, input logic hi, input logic [7:0] d,
                             input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; addr = a; byte_hi = hi; data = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ldac_n = 1'b0;
        @(negedge clk);
        ldac_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            mdl_in[i] = '0;
            mdl_out[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(64'(dac_val), 64'd0, "R1 codes in reset");
        check(64'(pd_flag), 64'd0, "R1 pd flags in reset");
        check(64'(gain_out), 64'd0, "R1 gain in reset");
        rst = 1'b0;
        @(negedge clk);
        check(64'(dac_val), 64'd0, "R1 codes after reset");

        // Table: R3 addressing, R4 byte split, R5 hold, R6 load
        for (int v = 0; v < 10; v++) begin
            logic [1:0] a;
            logic       h;
            logic [7:0] d;
            logic [9:0] e;
            {a, h, d, e} = VEC[v];
            bus_write(a, h, d, 1'b0);
            model_write(a, h, d);
            check(64'(dac_val), 64'(pack_out()), "R5 output holds before load");
            pulse_load();
            model_load();
            check(64'(dac_val[a*10 +: 10]), 64'(e), "R3/R4 channel code after load");
            check(64'(dac_val), 64'(pack_out()), "R4 other bytes and channels kept");
        end

        // R2: strobe with select high is ignored
        bus_write(2'd0, 1'b0, 8'hAA, 1'b1);
        pulse_load();
        check(64'(dac_val), 64'(pack_out()), "R2 write without select ignored");

        // R6: all four channels move on one edge
        bus_write(2'd0, 1'b0, 8'h11, 1'b0); model_write(2'd0, 1'b0, 8'h11);
        bus_write(2'd1, 1'b0, 8'h22, 1'b0); model_write(2'd1, 1'b0, 8'h22);
        bus_write(2'd2, 1'b0, 8'h33, 1'b0); model_write(2'd2, 1'b0, 8'h33);
        bus_write(2'd3, 1'b0, 8'h44, 1'b0); model_write(2'd3, 1'b0, 8'h44);
        check(64'(dac_val), 64'(pack_out()), "R5 four writes without load");
        @(negedge clk);
        ldac_n = 1'b0;
        @(negedge clk);
        check(64'(dac_val), 64'(pack_out()), "R6 no change one cycle after load");
        ldac_n = 1'b1;
        @(negedge clk);
        model_load();
        check(64'(dac_val), 64'({10'h144, 10'h333, 10'h022, 10'h311}), "R6 all channels updated together");

        // R7: load held low, write goes straight through
        @(negedge clk);
        ldac_n = 1'b0;
        bus_write(2'd1, 1'b1, 8'h01, 1'b0);
        model_write(2'd1, 1'b1, 8'h01);
        model_load();
        check(64'(dac_val[19:10]), 64'(10'h122), "R7 transparent write with load held");
        ldac_n = 1'b1;
        @(negedge clk);

        // R10: power-down flags, codes untouched
        pd_n = 1'b0;
        @(negedge clk);
        check(64'(pd_flag), 64'hF, "R10 power-down flags set");
        check(64'(dac_val), 64'(pack_out()), "R10 codes kept in power-down");
        pd_n = 1'b1;
        @(negedge clk);
        check(64'(pd_flag), 64'h0, "R10 power-down flags clear");

        // R11: gain pass-through
        gain_sel = 1'b1;
        @(negedge clk);
        check(64'(gain_out), 64'd1, "R11 gain high");
        gain_sel = 1'b0;
        @(negedge clk);
        check(64'(gain_out), 64'd0, "R11 gain low");

        // R8: asynchronous clear mid-cycle
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        check(64'(dac_val), 64'd0, "R8 clear without clock edge");
        @(negedge clk);
        clr_n = 1'b1;
        pulse_load();
        for (int i = 0; i < 4; i++) begin mdl_in[i] = '0; mdl_out[i] = '0; end
        check(64'(dac_val), 64'd0, "R8 input registers cleared too");

        // R9: clear wins over a write with load held
        @(negedge clk);
        clr_n = 1'b0;
        ldac_n = 1'b0;
        bus_write(2'd2, 1'b0, 8'h77, 1'b0);
        check(64'(dac_val), 64'd0, "R9 write blocked during clear");
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        check(64'(dac_val), 64'd0, "R9 write lost after clear");
        ldac_n = 1'b1;

        // R1: reset during operation
        bus_write(2'd0, 1'b0, 8'h55, 1'b0);
        pulse_load();
        check(64'(dac_val[9:0]), 64'(10'h055), "R3 channel 0 write before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(64'(dac_val), 64'd0, "R1 mid-run reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule